// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scanner with Key Matrix

This block drives a time-multiplexed fluorescent display and, in the same scan, reads a key matrix. Software writes one segment pattern per digit into a small display RAM and sets a control word that holds the digit count and the dimmer level. The scanner then steps through the digits in ascending order. Each digit turns on its timing line and its segment pattern for part of a fixed digit period. The dimmer sets how long that part is, and every digit period ends with a blank slot so that no pattern leaks into the next digit.

After the last digit comes a key slot group. In it all timing lines stay low and the first sixteen segment lines are raised one at a time. The eight key-return inputs are sampled at the end of each step, which gives an 8 by 16 key image. The whole image is published at once when the key slots end. If the new image differs from the one before it, a one-cycle interrupt pulse is raised. When eight or fewer digits are scanned, the upper eight timing lines are free and carry eight extra segment bits. This gives 29 segments per digit, against 21 segments per digit with 16 digits.

Top module: `vfd_scan`

## Requirements
- R1: While reset is asserted, and in the cycle after it, all timing lines, segment lines, the key image and the interrupt are low.
- R2: The control word sets the digit count to wr_data[3:0]+1. The digits are scanned in order 0 up to count-1. Each digit period is 9 slots, and each slot is PRESC clocks. In the display part at most one timing line of the scanned digits is high, and that line is tim_o[d] of the current digit d.
- R3: The dimmer level is wr_data[6:4] of the control word. A digit is lit for slots 0 to level, which is level+1 eighths of the 8 enable slots. Slot 8 is always blank. While a digit is not lit, all timing and segment lines are low.
- R4: While digit d is lit, seg_o[i] equals bit i of display word d, for i from 0 to 20.
- R5: With a digit count of 8 or less, tim_o[8+k] carries bit 28-k of the word while the digit is lit. With a count of 9 or more, those lines are timing lines and word bits 21 to 28 are not shown.
- R6: A display word is sampled when its digit period begins, so a write shows from the next digit boundary. A control write takes effect at the next frame start, which is the end of the key slots.
- R7: After the last digit come 16 key slots. In key slot j only seg_o[j] is high and all timing lines are low.
- R8: key_ret_i is sampled on the last clock of key slot j into key_img_o[8j+7:8j]. The 16 bytes are published together when the key slots end.
- R9: key_irq_o pulses for one cycle, together with the publication, when the new key image differs from the previous one. Otherwise it stays low.
- R10: Write addresses 0 to 15 select a display word and address 16 the control word. Writes to addresses 17 to 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address (word 0-15, control 16) |
| wr_data | input | 29 | Write data |
| key_ret_i | input | 8 | Key-return inputs |
| tim_o | output | 16 | Digit timing lines (upper 8 shared as segments) |
| seg_o | output | 21 | Dedicated segment lines, also key drive lines 0-15 |
| key_img_o | output | 128 | Published key image, byte j for drive line j |
| key_irq_o | output | 1 | Key-change pulse |

## Verification
The assertions assume that key_ret_i and the write port change only between clock edges and that reset is held for at least one edge. From then on, the one-hot, blanking and slot-stability properties depend only on the scanner's own counters. The bench drives every input on the falling edge. It derives the key returns from the segment line that the block itself raises while the timing lines are low, so the key inputs act like a real matrix and stay constant across each sampling edge. Random writes may hit any address, including the unused ones, and any control value, so every digit count and dimmer level is reached.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // Lit when the slot lies inside the enable window chosen by the dimmer.
  function automatic logic slot_lit(input int slot, input int dim, input int on_slots);
    return (slot < on_slots) && (slot <= dim);
  endfunction

  // Shared timing line k carries word bit (total-1-k).
  function automatic int shared_bit(input int k, input int total);
    return total - 1 - k;
  endfunction
endpackage

// File: rtl/vfd_regs.sv
module vfd_regs #(
  parameter int NDIG = 16,
  parameter int SEGT = 29,
  parameter int DIMW = 3,
  localparam int DW = $clog2(NDIG),
  localparam int AW = DW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [SEGT-1:0] wr_data,
  input  logic [DW-1:0]   rd_idx,
  output logic [SEGT-1:0] rd_word,
  output logic [DW-1:0]   nd_m1,
  output logic [DIMW-1:0] dim
);
  logic [SEGT-1:0] mem [NDIG];
  logic hit_word, hit_ctrl;

  assign hit_word = wr_en && (wr_addr[AW-1] == 1'b0);
  assign hit_ctrl = wr_en && (wr_addr == AW'(NDIG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDIG; i++) mem[i] <= '0;
      nd_m1 <= '0;
      dim   <= '0;
    end else begin
      if (hit_word) mem[wr_addr[DW-1:0]] <= wr_data;
      if (hit_ctrl) begin
        nd_m1 <= wr_data[DW-1:0];
        dim   <= wr_data[DW+DIMW-1:DW];
      end
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/vfd_timing.sv
module vfd_timing #(
  parameter int PRESC = 4,
  parameter int NDIG  = 16,
  parameter int DIMW  = 3,
  localparam int DW = $clog2(NDIG),
  localparam int ON_SLOTS = 1 << DIMW,
  localparam int BLANK_SLOT = ON_SLOTS,
  localparam int SMAX = (NDIG > BLANK_SLOT + 1) ? NDIG : BLANK_SLOT + 1,
  localparam int SW = $clog2(SMAX),
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   nd_m1_in,
  input  logic [DIMW-1:0] dim_in,
  output logic            phase_key,
  output logic [SW-1:0]   slot,
  output logic [DW-1:0]   digit,
  output logic [DW-1:0]   nxt_digit,
  output logic [DW-1:0]   nd_m1_f,
  output logic            tick,
  output logic            dig_start,
  output logic            key_cap,
  output logic            frame_end,
  output logic            lit
);
  logic [PW-1:0] presc;
  logic [DIMW-1:0] dim_f;
  logic end_disp, end_key, last_digit;

  assign tick       = (presc == PW'(PRESC - 1));
  assign end_disp   = !phase_key && (slot == SW'(BLANK_SLOT));
  assign end_key    = phase_key && (slot == SW'(NDIG - 1));
  assign last_digit = (digit == nd_m1_f);
  assign dig_start  = tick && ((end_disp && !last_digit) || end_key);
  assign frame_end  = tick && end_key;
  assign key_cap    = tick && phase_key;
  assign nxt_digit  = end_key ? '0 : digit + DW'(1);
  assign lit        = !phase_key && vfd_pkg::slot_lit(int'(slot), int'(dim_f), ON_SLOTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc     <= '0;
      phase_key <= 1'b0;
      slot      <= SW'(BLANK_SLOT);
      digit     <= '0;
      nd_m1_f   <= '0;
      dim_f     <= '0;
    end else begin
      presc <= tick ? '0 : presc + PW'(1);
      if (tick) begin
        if (end_key) begin
          phase_key <= 1'b0;
          slot      <= '0;
          digit     <= '0;
          nd_m1_f   <= nd_m1_in;
          dim_f     <= dim_in;
        end else if (end_disp) begin
          slot <= '0;
          if (last_digit) phase_key <= 1'b1;
          else            digit <= digit + DW'(1);
        end else begin
          slot <= slot + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vfd_segmux.sv
module vfd_segmux #(
  parameter int NDIG = 16,
  parameter int SEGD = 21,
  parameter int SHR  = 8,
  parameter int SW   = 4,
  localparam int SEGT = SEGD + SHR,
  localparam int DW = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dig_start,
  input  logic [SEGT-1:0] rd_word,
  input  logic            lit,
  input  logic            phase_key,
  input  logic [SW-1:0]   slot,
  input  logic [DW-1:0]   digit,
  input  logic [DW-1:0]   nd_m1_f,
  output logic [NDIG-1:0] tim_o,
  output logic [SEGD-1:0] seg_o
);
  logic [SEGT-1:0] shadow;
  logic share;

  always_ff @(posedge clk) begin
    if (!rst_n)         shadow <= '0;
    else if (dig_start) shadow <= rd_word;
  end

  assign share = (nd_m1_f < DW'(SHR));

  always_comb begin
    tim_o = '0;
    seg_o = '0;
    if (lit) begin
      tim_o[digit] = 1'b1;
      seg_o = shadow[SEGD-1:0];
      if (share) begin
        for (int k = 0; k < SHR; k++)
          tim_o[NDIG-SHR+k] = shadow[vfd_pkg::shared_bit(k, SEGT)];
      end
    end else if (phase_key) begin
      seg_o[slot] = 1'b1;
    end
  end
endmodule

// File: rtl/vfd_keyscan.sv
module vfd_keyscan #(
  parameter int NDIG  = 16,
  parameter int KROWS = 8,
  parameter int SW    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  key_cap,
  input  logic                  frame_end,
  input  logic [SW-1:0]         slot,
  input  logic [KROWS-1:0]      key_ret,
  output logic [NDIG*KROWS-1:0] img_o,
  output logic                  irq_o
);
  logic [NDIG-1:0][KROWS-1:0] work, fresh, img;

  always_comb begin
    fresh = work;
    fresh[slot] = key_ret;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work  <= '0;
      img   <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (key_cap) work <= fresh;
      if (frame_end) begin
        img   <= fresh;
        irq_o <= (fresh != img);
      end
    end
  end

  assign img_o = img;
endmodule

// File: rtl/vfd_scan.sv
module vfd_scan #(
  parameter int PRESC = 4,
  parameter int NDIG  = 16,
  parameter int SEGD  = 21,
  parameter int SHR   = 8,
  parameter int KROWS = 8,
  parameter int DIMW  = 3,
  localparam int SEGT = SEGD + SHR,
  localparam int DW = $clog2(NDIG),
  localparam int AW = DW + 1,
  localparam int SMAX = (NDIG > (1 << DIMW) + 1) ? NDIG : (1 << DIMW) + 1,
  localparam int SW = $clog2(SMAX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [SEGT-1:0]       wr_data,
  input  logic [KROWS-1:0]      key_ret_i,
  output logic [NDIG-1:0]       tim_o,
  output logic [SEGD-1:0]       seg_o,
  output logic [NDIG*KROWS-1:0] key_img_o,
  output logic                  key_irq_o
);
  logic [SEGT-1:0] rd_word;
  logic [DW-1:0]   nd_m1, nd_m1_f, digit, nxt_digit;
  logic [DIMW-1:0] dim;
  logic [SW-1:0]   slot;
  logic phase_key, tick, dig_start, key_cap, frame_end, lit;

  vfd_regs #(.NDIG(NDIG), .SEGT(SEGT), .DIMW(DIMW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(nxt_digit), .rd_word(rd_word), .nd_m1(nd_m1), .dim(dim)
  );

  vfd_timing #(.PRESC(PRESC), .NDIG(NDIG), .DIMW(DIMW)) u_timing (
    .clk(clk), .rst_n(rst_n), .nd_m1_in(nd_m1), .dim_in(dim),
    .phase_key(phase_key), .slot(slot), .digit(digit), .nxt_digit(nxt_digit),
    .nd_m1_f(nd_m1_f), .tick(tick), .dig_start(dig_start), .key_cap(key_cap),
    .frame_end(frame_end), .lit(lit)
  );

  vfd_segmux #(.NDIG(NDIG), .SEGD(SEGD), .SHR(SHR), .SW(SW)) u_segmux (
    .clk(clk), .rst_n(rst_n), .dig_start(dig_start), .rd_word(rd_word), .lit(lit),
    .phase_key(phase_key), .slot(slot), .digit(digit), .nd_m1_f(nd_m1_f),
    .tim_o(tim_o), .seg_o(seg_o)
  );

  vfd_keyscan #(.NDIG(NDIG), .KROWS(KROWS), .SW(SW)) u_keyscan (
    .clk(clk), .rst_n(rst_n), .key_cap(key_cap), .frame_end(frame_end), .slot(slot),
    .key_ret(key_ret_i), .img_o(key_img_o), .irq_o(key_irq_o)
  );
endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter int NDIG = 16,
  parameter int SEGD = 21,
  parameter int SHR  = 8,
  localparam int DW = $clog2(NDIG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDIG-1:0] tim_o,
  input logic [SEGD-1:0] seg_o,
  input logic            key_irq_o,
  input logic            phase_key,
  input logic            lit,
  input logic            tick,
  input logic            frame_end,
  input logic [DW-1:0]   nd_m1_f
);
  logic share;
  assign share = (nd_m1_f < DW'(SHR));

  // R1: outputs quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (tim_o == '0 && seg_o == '0 && !key_irq_o));

  // R2: at most one digit line in the display part
  a_r2_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_key |-> $onehot0(share ? {{(NDIG-SHR){1'b0}}, tim_o[SHR-1:0]} : tim_o));

  // R3: dark outside the dimmer window
  a_r3_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_key && !lit) |-> (tim_o == '0 && seg_o == '0));

  // R7: exactly one drive line and no digit during key slots
  a_r7_key_drive: assert property (@(posedge clk) disable iff (!rst_n)
    phase_key |-> (tim_o == '0 && $countones(seg_o) == 1));

  // R9: interrupt only right after the key slots end
  a_r9_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq_o |-> $past(frame_end));

  // R6: outputs hold inside a slot
  a_r6_hold_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(tim_o) && $stable(seg_o)));
endmodule

bind vfd_scan vfd_scan_chk #(.NDIG(NDIG), .SEGD(SEGD), .SHR(SHR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tim_o(tim_o), .seg_o(seg_o), .key_irq_o(key_irq_o),
  .phase_key(phase_key), .lit(lit), .tick(tick), .frame_end(frame_end), .nd_m1_f(nd_m1_f)
);

// File: tb/vfd_scan_tb.sv
module vfd_scan_tb;
  localparam int P = 4;
  localparam int DP = 9 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [28:0] wr_data = '0;
  logic [7:0] key_ret;
  logic [15:0] tim_o;
  logic [20:0] seg_o;
  logic [127:0] key_img_o;
  logic key_irq_o;

  always #4 clk = ~clk;

  vfd_scan #(.PRESC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .key_ret_i(key_ret), .tim_o(tim_o), .seg_o(seg_o), .key_img_o(key_img_o),
    .key_irq_o(key_irq_o)
  );

  // Key matrix: return lines see the keys on a raised drive line while no digit is on.
  logic [7:0] keys [16];
  always_comb begin
    key_ret = '0;
    if (tim_o == '0)
      for (int j = 0; j < 16; j++) if (seg_o[j]) key_ret = key_ret | keys[j];
  end

  int total = 0, fails = 0;
  bit done = 0, chk_on = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Timeline model: edges since reset release, offset within the current frame.
  int k, fbeg, fnd, fdim, mnd, mdim;
  logic [28:0] mram [16];
  logic [28:0] cpat;
  logic [7:0] kw [16];
  logic [7:0] ki [16];
  logic irq_e;

  always @(posedge clk) begin
    int o, L, j;
    bit ch;
    if (!rst_n) begin
      k = 0; fbeg = -8 * P; fnd = 1; fdim = 0; mnd = 1; mdim = 0;
      cpat = '0; irq_e = 0;
      for (int i = 0; i < 16; i++) begin mram[i] = '0; kw[i] = '0; ki[i] = '0; end
    end else begin
      k++;
      o = k - fbeg;
      L = fnd * DP + 16 * P;
      irq_e = 0;
      if (o > fnd * DP && (o - fnd * DP) % P == 0) begin
        j = (o - fnd * DP) / P - 1;
        kw[j] = keys[j];
      end
      if (o == L) begin
        ch = 0;
        for (int i = 0; i < 16; i++) begin ch |= (kw[i] != ki[i]); ki[i] = kw[i]; end
        irq_e = ch; fbeg = k; o = 0; fnd = mnd; fdim = mdim;
      end
      if (o < fnd * DP && o % DP == 0) cpat = mram[o / DP];
      if (wr_en) begin
        if (wr_addr < 16) mram[wr_addr] = wr_data;
        else if (wr_addr == 16) begin mnd = int'(wr_data[3:0]) + 1; mdim = int'(wr_data[6:4]); end
      end
    end
  end

  always @(negedge clk) begin
    int o, d, s, j;
    bit on;
    logic [15:0] et;
    logic [20:0] es;
    logic [127:0] eimg;
    if (rst_n && chk_on) begin
      o = k - fbeg; et = '0; es = '0;
      for (int i = 0; i < 16; i++) eimg[8*i +: 8] = ki[i];
      if (o < fnd * DP) begin
        d = o / DP; s = (o % DP) / P;
        on = (s < 8) && (s <= fdim);
        if (on) begin
          et[d] = 1'b1; es = cpat[20:0];
          if (fnd <= 8) for (int q = 0; q < 8; q++) et[8+q] = cpat[28-q];
          check("R2/R5 timing lines", 128'(tim_o), 128'(et));
          check("R4/R6/R10 segment lines", 128'(seg_o), 128'(es));
        end else begin
          check("R3 dimmed timing", 128'(tim_o), 128'(et));
          check("R3 dimmed segments", 128'(seg_o), 128'(es));
        end
      end else begin
        j = (o - fnd * DP) / P;
        es[j] = 1'b1;
        check("R7 key slot timing", 128'(tim_o), 128'(et));
        check("R7 key slot drive", 128'(seg_o), 128'(es));
      end
      check("R8 key image", key_img_o, eimg);
      check("R9 key interrupt", 128'(key_irq_o), 128'(irq_e));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [28:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset timing", 128'(tim_o), 128'(0));
    check("R1 reset segments", 128'(seg_o), 128'(0));
    check("R1 reset image", key_img_o, 128'(0));
    check("R1 reset irq", 128'(key_irq_o), 128'(0));
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) keys[i] = '0;
    @(negedge clk);
    reset_check();
    chk_on = 1;
    // Directed: one digit, full brightness, all-ones word, keys pressed.
    wr(5'd0, '1);
    wr(5'd16, 29'h70);
    keys[0] = 8'h81; keys[15] = 8'h3c;
    repeat (600) @(negedge clk);
    // Directed: sixteen digits, dimmest level.
    for (int i = 0; i < 16; i++) wr(5'(i), 29'($urandom));
    wr(5'd16, 29'h0f);
    repeat (1500) @(negedge clk);
    // Directed: boundary counts 8 and 9 (shared lines on/off).
    wr(5'd16, 29'h37);
    repeat (1200) @(negedge clk);
    wr(5'd16, 29'h58);
    keys[15] = 8'h00;
    repeat (1200) @(negedge clk);
    // Unused addresses must not disturb the display.
    for (int a = 17; a < 32; a++) wr(5'(a), '1);
    repeat (1000) @(negedge clk);
    // Random mix of writes and key changes.
    for (int n = 0; n < 30000; n++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if ($urandom % 8 == 0) begin
        wr_en = 1'b1; wr_addr = 5'($urandom); wr_data = 29'($urandom);
        if ($urandom % 4 == 0) wr_addr = 5'd16;
      end
      if ($urandom % 64 == 0) keys[$urandom % 16] = 8'($urandom);
      if (n == 15000) begin
        wr_en = 1'b0; chk_on = 0;
        reset_check();
        chk_on = 1;
      end
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (1500) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule